// File: doc/BRIEF.md
# Two's Complement Float Multiplier

A purely combinational multiplier for floating-point numbers whose fraction and exponent are both two's complement. A number has a signed fraction `f` of `FRAC_W` bits (25 by default) and a signed, unbiased exponent `e` of `EXP_W` bits (8 by default). Its value is `f / 2^(FRAC_W-1) * 2^e`. There is no separate sign bit, no hidden leading one and no bias. A normal number has an exponent other than the most negative one, and the two top bits of its fraction differ. The sign is the fraction MSB.

The most negative exponent (the reserved exponent) marks the non-normal states. At that exponent the fraction selects the state by its top three bits. All zeros is zero. `000` with a non-zero rest, or `111`, is vanished (an underflow), and the MSB keeps its sign. `01x` or `10x` is exploded (an overflow), and the MSB is its sign. `001` is infinity. `110` is undefined. The block always emits the canonical codes for these states. Zero is all zeros. Vanished is `0…01` when positive and `1…1` when negative. Exploded is `010…0` when positive and `100…0` when negative. Infinity is `0010…0` and undefined is `1100…0`.

The product takes one pass. The signed fractions are multiplied at full width. When the `negate` input is set, the exact product is negated before rounding, so `-(a*b)` is rounded only once. The result is normalized by a right shift of one bit, no shift, or a left shift of one bit, and rounded to nearest-even. The exponents are summed and the normalize and rounding adjustments are added. A result outside the exponent range saturates to exploded or vanished. Operands with a non-reserved exponent are assumed to be normal.

Top module: `tcf_mul`

## Requirements
- R1: Whenever the output exponent is not the reserved value, the two top bits of the output fraction differ.
- R2: A product that is exact at `FRAC_W` bits is returned unrounded. Its exponent is `e_a + e_b` plus the normalize adjustment (+1, 0 or -1), with no bias term. Examples: 0.5×0.5 gives fraction `010…0` at exponent -1. (-1 at exponent 3)×(-1 at exponent 4) gives `010…0` at exponent 8.
- R3: For two normal operands, the output is the exact product rounded to nearest, with ties going to an even LSB.
- R4: A rounding carry that leaves the normal range is folded back. A positive fraction that rounds up to `1.0` becomes `010…0` with the exponent plus one. A negative fraction that rounds to `110…0` becomes `100…0` with the exponent minus one.
- R5: With `negate` high, the output is the once-rounded value of `-(a*b)`. This holds also when either fraction is the most negative pattern `100…0`.
- R6: The output is zero (fraction all zeros at the reserved exponent) exactly when either operand is zero and neither is undefined, and the other operand is not infinity.
- R7: A normal product whose final exponent is above the largest exponent becomes exploded. Its sign is the sign of the fraction-MSB XOR, inverted by `negate`.
- R8: A normal product whose final exponent is below the smallest normal exponent becomes vanished, carrying the same sign as in R7.
- R9: An undefined operand gives undefined. Zero times infinity gives undefined. Infinity times any non-zero operand gives infinity.
- R10: Exploded times vanished gives undefined. Otherwise an exploded operand gives exploded, and otherwise a vanished operand gives vanished, each carrying the sign from R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_frac | input | FRAC_W | Fraction of operand A |
| a_exp | input | EXP_W | Exponent of operand A |
| b_frac | input | FRAC_W | Fraction of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| negate | input | 1 | Return the negated product |
| y_frac | output | FRAC_W | Fraction of the result |
| y_exp | output | EXP_W | Exponent of the result |

## Verification
Most of the checking is done on a 6-bit-fraction, 4-bit-exponent instance, which is swept over every normal fraction pair, a spread of exponents and both `negate` values. The expected result comes from an arithmetic model using reals. That sweep reaches both ways a rounding carry can leave the normal range. A design that skipped either fold would return `100000`-style or `110000`-style fractions that are not normal. The sweep also reaches exponent sums past both limits, where a wrapped exponent would appear as a wrong normal value instead of exploded or vanished.

On the full-width instance, directed cases cover the most negative fraction squared and its negation, where a design that negates the operand instead of the product would get the sign wrong. They also cover the 25-bit fold on a negative product, and the special-state table including zero times infinity.

// File: rtl/tcf_mul.sv
module tcf_mul #(
  parameter int FRAC_W = 25,
  parameter int EXP_W  = 8
) (
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic              negate,
  output logic [FRAC_W-1:0] y_frac,
  output logic [EXP_W-1:0]  y_exp
);

  localparam int PW = 2 * FRAC_W;
  localparam int XW = EXP_W + 2;
  localparam logic [EXP_W-1:0]  RSV    = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] C_ZERO = '0;
  localparam logic [FRAC_W-1:0] C_VPOS = FRAC_W'(1);
  localparam logic [FRAC_W-1:0] C_VNEG = '1;
  localparam logic [FRAC_W-1:0] C_XPOS = {2'b01, {(FRAC_W-2){1'b0}}};
  localparam logic [FRAC_W-1:0] C_XNEG = {2'b10, {(FRAC_W-2){1'b0}}};
  localparam logic [FRAC_W-1:0] C_INF  = {3'b001, {(FRAC_W-3){1'b0}}};
  localparam logic [FRAC_W-1:0] C_UND  = {3'b110, {(FRAC_W-3){1'b0}}};
  localparam logic signed [XW-1:0] TOP = XW'(2**(EXP_W-1) - 1);
  localparam logic signed [XW-1:0] BOT = -TOP;

  // {undefined, infinity, exploded, vanished, zero}
  function automatic logic [4:0] kind(input logic [FRAC_W-1:0] f, input logic rsv);
    logic [2:0] t;
    t    = f[FRAC_W-1 -: 3];
    kind = '0;
    if (rsv) begin
      kind[0] = (f == '0);
      kind[1] = ((t == 3'b000) && (f != '0)) || (t == 3'b111);
      kind[2] = f[FRAC_W-1] ^ f[FRAC_W-2];
      kind[3] = (t == 3'b001);
      kind[4] = (t == 3'b110);
    end
  endfunction

  logic [4:0] ka, kb;
  logic       sgn, undef_c;

  assign ka      = kind(a_frac, a_exp == RSV);
  assign kb      = kind(b_frac, b_exp == RSV);
  assign sgn     = a_frac[FRAC_W-1] ^ b_frac[FRAC_W-1] ^ negate;
  assign undef_c = ka[4] | kb[4] | (ka[0] & kb[3]) | (ka[3] & kb[0])
                 | (ka[2] & kb[1]) | (ka[1] & kb[2]);

  logic signed [PW-1:0] prod, pn;
  logic                 hi, mid;
  logic [PW-2:0]        q;
  logic [FRAC_W-1:0]    keep;
  logic                 rnd, stk, up;
  logic [FRAC_W:0]      r;
  logic                 pos_wrap, neg_fold;
  logic [FRAC_W-1:0]    nfrac;
  logic signed [XW-1:0] adj_n, adj_r, es;

  assign prod = $signed({{FRAC_W{a_frac[FRAC_W-1]}}, a_frac})
              * $signed({{FRAC_W{b_frac[FRAC_W-1]}}, b_frac});
  assign pn   = negate ? -prod : prod;

  assign hi   = pn[PW-1] ^ pn[PW-2];
  assign mid  = pn[PW-2] ^ pn[PW-3];
  assign q    = hi ? pn[PW-1:1] : (mid ? pn[PW-2:0] : {pn[PW-3:0], 1'b0});

  assign keep = q[PW-2 -: FRAC_W];
  assign rnd  = q[FRAC_W-2];
  assign stk  = |q[FRAC_W-3:0];
  assign up   = rnd & (stk | keep[0]);
  assign r    = {keep[FRAC_W-1], keep} + {{FRAC_W{1'b0}}, up};

  assign pos_wrap = ~r[FRAC_W] & r[FRAC_W-1];
  assign neg_fold = r[FRAC_W] & r[FRAC_W-1] & r[FRAC_W-2];
  assign nfrac    = pos_wrap ? C_XPOS : (neg_fold ? C_XNEG : r[FRAC_W-1:0]);

  assign adj_n = hi ? XW'(1) : (mid ? '0 : '1);
  assign adj_r = pos_wrap ? XW'(1) : (neg_fold ? '1 : '0);
  assign es    = $signed({{2{a_exp[EXP_W-1]}}, a_exp})
               + $signed({{2{b_exp[EXP_W-1]}}, b_exp}) + adj_n + adj_r;

  always_comb begin
    y_exp = RSV;
    if (undef_c)               y_frac = C_UND;
    else if (ka[0] | kb[0])    y_frac = C_ZERO;
    else if (ka[3] | kb[3])    y_frac = C_INF;
    else if (ka[2] | kb[2])    y_frac = sgn ? C_XNEG : C_XPOS;
    else if (ka[1] | kb[1])    y_frac = sgn ? C_VNEG : C_VPOS;
    else if (es > TOP)         y_frac = sgn ? C_XNEG : C_XPOS;
    else if (es < BOT)         y_frac = sgn ? C_VNEG : C_VPOS;
    else begin
      y_frac = nfrac;
      y_exp  = es[EXP_W-1:0];
    end
  end

endmodule

module tcf_mul_chk #(
  parameter int FRAC_W = 25,
  parameter int EXP_W  = 8
) (
  input logic [FRAC_W-1:0] a_frac,
  input logic [EXP_W-1:0]  a_exp,
  input logic [FRAC_W-1:0] b_frac,
  input logic [EXP_W-1:0]  b_exp,
  input logic              negate,
  input logic [FRAC_W-1:0] y_frac,
  input logic [EXP_W-1:0]  y_exp
);
  localparam logic [EXP_W-1:0] RSV = {1'b1, {(EXP_W-1){1'b0}}};

  logic a_zero, b_zero, a_norm, b_norm, a_und, y_norm;
  assign a_zero = (a_exp == RSV) && (a_frac == '0);
  assign b_zero = (b_exp == RSV) && (b_frac == '0);
  assign a_norm = a_exp != RSV;
  assign b_norm = b_exp != RSV;
  assign a_und  = (a_exp == RSV) && (a_frac[FRAC_W-1 -: 3] == 3'b110);
  assign y_norm = y_exp != RSV;

  always_comb begin
    // R1
    normal_form_chk: assert (!y_norm || (y_frac[FRAC_W-1] != y_frac[FRAC_W-2]))
      else $error("normal output with equal top fraction bits");
    // R6
    zero_source_chk: assert (y_norm || (y_frac != '0) || a_zero || b_zero)
      else $error("zero output from two non-zero operands");
    // R9
    undef_prop_chk: assert (!a_und || (!y_norm && y_frac[FRAC_W-1 -: 3] == 3'b110))
      else $error("undefined operand did not propagate");
    // R5
    sign_chk: assert (!(a_norm && b_norm && y_norm)
                      || (y_frac[FRAC_W-1] == (a_frac[FRAC_W-1] ^ b_frac[FRAC_W-1] ^ negate)))
      else $error("normal product has the wrong sign");
    // R7
    special_code_chk: assert (y_norm || (y_frac[FRAC_W-4:1] == '0) || (y_frac == '1))
      else $error("non-canonical special output");
  end
endmodule

bind tcf_mul tcf_mul_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .a_frac(a_frac), .a_exp(a_exp), .b_frac(b_frac), .b_exp(b_exp),
  .negate(negate), .y_frac(y_frac), .y_exp(y_exp)
);

// File: tb/test_tcf_mul.sv
module test_tcf_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // small instance: 6-bit fraction, 4-bit exponent
  logic [5:0] sa_f, sb_f, sy_f;
  logic [3:0] sa_e, sb_e, sy_e;
  logic       s_neg;

  tcf_mul #(.FRAC_W(6), .EXP_W(4)) i_tcf_mul (
    .a_frac(sa_f), .a_exp(sa_e), .b_frac(sb_f), .b_exp(sb_e),
    .negate(s_neg), .y_frac(sy_f), .y_exp(sy_e)
  );

  // default-size instance
  logic [24:0] wa_f, wb_f, wy_f;
  logic [7:0]  wa_e, wb_e, wy_e;
  logic        w_neg;

  tcf_mul i_tcf_mul_w (
    .a_frac(wa_f), .a_exp(wa_e), .b_frac(wb_f), .b_exp(wb_e),
    .negate(w_neg), .y_frac(wy_f), .y_exp(wy_e)
  );

  localparam logic [5:0] S_Z = 6'b000000, S_VP = 6'b000001, S_VN = 6'b111111,
                         S_XP = 6'b010000, S_XN = 6'b100000,
                         S_INF = 6'b001000, S_UND = 6'b110000;
  localparam logic [3:0] S_RSV = 4'b1000;

  localparam logic [24:0] W_Z = 25'h0000000, W_VN = 25'h1FFFFFF, W_VP = 25'h0000001,
                          W_XP = 25'h0800000, W_XN = 25'h1000000,
                          W_INF = 25'h0400000, W_UND = 25'h1800000;
  localparam logic [7:0]  W_RSV = 8'h80;

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic real pow2(input int k);
    real v = 1.0;
    if (k >= 0) repeat (k) v = v * 2.0;
    else repeat (-k) v = v / 2.0;
    return v;
  endfunction

  function automatic int rne(input real x);
    real fl = $floor(x);
    real d  = x - fl;
    int  i  = int'(fl);
    if (d > 0.5) i = i + 1;
    else if (d == 0.5 && (i % 2 != 0)) i = i + 1;
    return i;
  endfunction

  // arithmetic model for two normal operands of the small instance
  task automatic ref_norm(input int fa, input int ea, input int fb, input int eb,
                          input bit neg, output logic [5:0] f, output logic [3:0] e,
                          output string tag);
    int  p = fa * fb;
    int  ef = 0;
    int  fi;
    real xf = 0.0;
    if (neg) p = -p;
    for (int c = ea + eb - 2; c <= ea + eb + 2; c++) begin
      real x = real'(p) * pow2(ea + eb - c - 5);
      if ((x >= 16.0 && x < 32.0) || (x >= -32.0 && x < -16.0)) begin
        ef = c;
        xf = x;
      end
    end
    fi  = rne(xf);
    tag = neg ? "R5" : "R3";
    if (fi == 32)       begin fi = 16;  ef++; tag = "R4"; end
    else if (fi == -16) begin fi = -32; ef--; tag = "R4"; end
    if (ef > 7) begin
      f = (p < 0) ? S_XN : S_XP; e = S_RSV; tag = "R7";
    end else if (ef < -7) begin
      f = (p < 0) ? S_VN : S_VP; e = S_RSV; tag = "R8";
    end else begin
      f = 6'(fi); e = 4'(ef);
    end
  endtask

  // 0 normal, 1 zero, 2 vanished, 3 exploded, 4 infinity, 5 undefined
  function automatic int cls(input logic [5:0] f, input logic [3:0] e);
    if (e != S_RSV) return 0;
    if (f == 6'd0) return 1;
    case (f[5:3])
      3'b000, 3'b111: return 2;
      3'b001:         return 4;
      3'b110:         return 5;
      default:        return 3;
    endcase
  endfunction

  task automatic ref_any(input logic [5:0] af, input logic [3:0] ae, input logic [5:0] bf,
                         input logic [3:0] be, input bit neg, output logic [5:0] f,
                         output logic [3:0] e, output string tag);
    int ca = cls(af, ae);
    int cb = cls(bf, be);
    bit sg = af[5] ^ bf[5] ^ neg;
    e = S_RSV;
    if (ca == 5 || cb == 5 || (ca == 1 && cb == 4) || (ca == 4 && cb == 1)) begin
      f = S_UND; tag = "R9";
    end else if ((ca == 3 && cb == 2) || (ca == 2 && cb == 3)) begin
      f = S_UND; tag = "R10";
    end else if (ca == 1 || cb == 1) begin
      f = S_Z; tag = "R6";
    end else if (ca == 4 || cb == 4) begin
      f = S_INF; tag = "R9";
    end else if (ca == 3 || cb == 3) begin
      f = sg ? S_XN : S_XP; tag = "R10";
    end else if (ca == 2 || cb == 2) begin
      f = sg ? S_VN : S_VP; tag = "R10";
    end else begin
      ref_norm(int'($signed(af)), int'($signed(ae)), int'($signed(bf)), int'($signed(be)),
               neg, f, e, tag);
    end
  endtask

  task automatic wchk(input string tag, input logic [24:0] af, input logic [7:0] ae,
                      input logic [24:0] bf, input logic [7:0] be, input logic neg,
                      input logic [24:0] ef, input logic [7:0] ee);
    wa_f = af; wa_e = ae; wb_f = bf; wb_e = be; w_neg = neg;
    #1;
    chk(tag, {7'd0, wy_f, wy_e}, {7'd0, ef, ee});
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam int ELIST [7] = '{-7, -4, -1, 0, 2, 5, 7};
  localparam logic [5:0] SPF [11] = '{S_Z, S_VP, S_VN, S_XP, S_XN, S_INF, S_UND,
                                      6'b010000, 6'b100000, 6'b011111, 6'b101111};
  localparam logic [3:0] SPE [11] = '{S_RSV, S_RSV, S_RSV, S_RSV, S_RSV, S_RSV, S_RSV,
                                      4'd0, 4'd0, 4'd3, 4'b1011};

  initial begin
    logic [5:0] ef;
    logic [3:0] ee;
    string      tag;

    // idle state: both operands zero
    sa_f = S_Z; sa_e = S_RSV; sb_f = S_Z; sb_e = S_RSV; s_neg = 1'b0;
    wa_f = W_Z; wa_e = W_RSV; wb_f = W_Z; wb_e = W_RSV; w_neg = 1'b0;
    #1;
    chk("R6 idle small", {30'd0, sy_f, sy_e}, {30'd0, S_Z, S_RSV});
    chk("R6 idle wide", {7'd0, wy_f, wy_e}, {7'd0, W_Z, W_RSV});

    // full-width directed cases
    wchk("R2 half*half", W_XP, 8'd0, W_XP, 8'd0, 1'b0, W_XP, 8'hFF);
    wchk("R2 min*min", W_XN, 8'd3, W_XN, 8'd4, 1'b0, W_XP, 8'd8);
    wchk("R5 neg min*half", W_XN, 8'd0, W_XP, 8'd0, 1'b1, W_XP, 8'd0);
    wchk("R5 neg min*min", W_XN, 8'd2, W_XN, 8'hFF, 1'b1, W_XN, 8'd1);
    wchk("R4 negative fold", 25'h17FFFFF, 8'd0, 25'h0FFFFFF, 8'd0, 1'b0, W_XN, 8'hFF);
    wchk("R7 overflow", W_XP, 8'd127, W_XN, 8'd127, 1'b0, W_XN, W_RSV);
    wchk("R8 underflow", W_XP, 8'h81, W_XP, 8'h81, 1'b1, W_VN, W_RSV);
    wchk("R6 zero*normal", W_Z, W_RSV, W_XN, 8'd5, 1'b1, W_Z, W_RSV);
    wchk("R9 inf*zero", W_INF, W_RSV, W_Z, W_RSV, 1'b0, W_UND, W_RSV);
    wchk("R9 inf*normal", W_INF, W_RSV, W_XP, 8'd0, 1'b1, W_INF, W_RSV);
    wchk("R9 undef*normal", W_UND, W_RSV, W_XP, 8'd0, 1'b0, W_UND, W_RSV);
    wchk("R10 exploded*vanished", W_XP, W_RSV, W_VN, W_RSV, 1'b0, W_UND, W_RSV);
    wchk("R10 exploded*normal", W_XN, W_RSV, W_XP, 8'd0, 1'b1, W_XP, W_RSV);

    // special-state table on the small instance
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++)
        for (int n = 0; n < 2; n++) begin
          sa_f = SPF[i]; sa_e = SPE[i]; sb_f = SPF[j]; sb_e = SPE[j]; s_neg = n[0];
          #1;
          ref_any(SPF[i], SPE[i], SPF[j], SPE[j], n[0], ef, ee, tag);
          chk(tag, {30'd0, sy_f, sy_e}, {30'd0, ef, ee});
        end

    // sweep of all normal fraction pairs (R1, R3, R4, R5, R7, R8)
    for (int ia = 0; ia < 32; ia++)
      for (int xa = 0; xa < 7; xa++)
        for (int ib = 0; ib < 32; ib++)
          for (int xb = 0; xb < 7; xb++)
            for (int n = 0; n < 2; n++) begin
              int fa = (ia < 16) ? 16 + ia : ia - 48;
              int fb = (ib < 16) ? 16 + ib : ib - 48;
              sa_f = 6'(fa); sa_e = 4'(ELIST[xa]);
              sb_f = 6'(fb); sb_e = 4'(ELIST[xb]);
              s_neg = n[0];
              #1;
              ref_norm(fa, ELIST[xa], fb, ELIST[xb], n[0], ef, ee, tag);
              chk(tag, {30'd0, sy_f, sy_e}, {30'd0, ef, ee});
            end

    finish_run();
  end
endmodule